// File: doc/BRIEF.md
# Preloadable Down-Counting Interval Timer

A 32-bit down counter for an operating-system tick source. A slow tick enable, nominally 32768 Hz, decrements it. Software writes a preload value, then starts the counter by moving the start bit of the control register from 0 to 1. That edge copies the preload into the count, which then decrements once per tick enable while the timer runs. When the count expires, a sticky status flag is set. Software clears the flag by writing 1 to it. The interrupt output is the flag gated by an enable bit.

In one-shot mode the count stays at zero after it expires. An interrupt handler that reads a nonzero count therefore knows the interrupt is stale. In reload mode the count is refilled from the preload register at expiry. A preload written while the timer runs has no effect on the count in progress and is first used at that refill or at the next start edge. A debug-halt input can freeze the counter when the control register permits it.

Top module: `rtos_down_timer`

## Requirements
- R1: After reset the count, preload, control and status registers all read 0, and irq_o is 0.
- R2: The count register (address 0) is read-only. Writes to it are accepted and have no effect.
- R3: A write to control (address 2) that sets start (bit 1) while start is currently 0 loads the count from preload (address 1). A write that leaves start at 1 does not reload.
- R4: While block-enable (bit 0) and start are both 1, each cycle with tick_i high lowers a nonzero count by one. Cycles without tick_i leave the count unchanged.
- R5: With block-enable at 0, tick_i has no effect on the count. Register writes are still accepted and read back.
- R6: A preload write while running leaves the current count unchanged. In reload mode (control bit 3) the new value is loaded when the count expires.
- R7: The status flag (address 3, bit 0) is set on the tick that moves the count from 1 to 0. After a start edge with preload 0, it is set on the first tick.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set.
- R9: irq_o equals the status flag ANDed with the interrupt enable (address 3, bit 1, read/write).
- R10: With halt-enable (control bit 2) at 1, the count is frozen while dbg_halt_i is high. With halt-enable at 0, dbg_halt_i has no effect.
- R11: In one-shot mode (bit 3 = 0) the count stays at 0 after expiry, and further ticks do not set the flag again.
- R12: Writing 0 to the control register stops counting and leaves the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable pulse at the fixed tick rate |
| dbg_halt_i | input | 1 | CPU debug halt |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Register address: 0 count, 1 preload, 2 control, 3 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is an armed counter that is already at zero, because the count can only be set through the preload path. The bench reaches it by starting the timer with a preload of 0 and checking that the flag is raised exactly once. It also reaches a pending preload change while running in reload mode, and checks that the new value is loaded only at expiry. Start edges are separated from start-held rewrites by writing a control value whose start bit is already 1.

// File: rtl/rtos_timer_pkg.sv
package rtos_timer_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_COUNT   = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd3;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_START  = 1;
  localparam int unsigned B_HALTEN = 2;
  localparam int unsigned B_RELOAD = 3;
  localparam int unsigned CTRL_W   = 4;

  localparam int unsigned S_FLAG  = 0;
  localparam int unsigned S_IRQEN = 1;

  typedef struct packed {
    logic reload;
    logic halt_en;
    logic start;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/rtos_timer_regs.sv
module rtos_timer_regs
  import rtos_timer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      count_i,
  input  logic              flag_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      preload_o,
  output ctrl_t             ctrl_o,
  output logic              irq_en_o,
  output logic              start_edge_o,
  output logic              flag_clr_o
);
  logic wr;
  ctrl_t ctrl_q;
  logic [W-1:0] pre_q;
  logic irq_en_q;

  assign wr = req_i & we_i;
  assign start_edge_o = wr && addr_i == A_CTRL && wdata_i[B_START] && !ctrl_q.start;
  assign flag_clr_o   = wr && addr_i == A_STATUS && wdata_i[S_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      irq_en_q <= 1'b0;
    end else if (wr) begin
      case (addr_i)
        A_PRELOAD: pre_q    <= wdata_i;
        A_CTRL:    ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        A_STATUS:  irq_en_q <= wdata_i[S_IRQEN];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_COUNT:   rdata_o = count_i;
      A_PRELOAD: rdata_o = pre_q;
      A_CTRL:    rdata_o[CTRL_W-1:0] = ctrl_q;
      A_STATUS:  begin
        rdata_o[S_FLAG]  = flag_i;
        rdata_o[S_IRQEN] = irq_en_q;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign preload_o = pre_q;
  assign ctrl_o    = ctrl_q;
  assign irq_en_o  = irq_en_q;
endmodule

// File: rtl/rtos_timer_core.sv
module rtos_timer_core
  import rtos_timer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         dbg_halt_i,
  input  ctrl_t        ctrl_i,
  input  logic [W-1:0] preload_i,
  input  logic         start_edge_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] count_o,
  output logic         flag_o
);
  logic [W-1:0] cnt_q;
  logic armed_q, flag_q;
  logic run, step, expire;

  assign run    = ctrl_i.en & ctrl_i.start & ~(ctrl_i.halt_en & dbg_halt_i);
  assign step   = tick_i & run & ~start_edge_i;
  // expiry: 1 -> 0, or an armed counter already sitting at 0
  assign expire = step & armed_q & (cnt_q <= W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_edge_i) begin
      cnt_q   <= preload_i;
      armed_q <= 1'b1;
    end else if (expire) begin
      cnt_q   <= ctrl_i.reload ? preload_i : '0;
      armed_q <= ctrl_i.reload;
    end else if (step && cnt_q != '0) begin
      cnt_q   <= cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (expire)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;

  p_count_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_edge_i) |=> $stable(cnt_q));
  p_halt_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.halt_en && dbg_halt_i && !start_edge_i) |=> $stable(cnt_q));
  p_flag_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i));
  p_oneshot_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ctrl_i.reload && !start_edge_i) |=> cnt_q == '0);
  p_no_dec_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !start_edge_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtos_down_timer.sv
module rtos_down_timer
  import rtos_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              dbg_halt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] count, preload;
  ctrl_t ctrl;
  logic flag, irq_en, start_edge, flag_clr;

  rtos_timer_regs #(.W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .count_i(count), .flag_i(flag), .rdata_o,
    .preload_o(preload), .ctrl_o(ctrl), .irq_en_o(irq_en),
    .start_edge_o(start_edge), .flag_clr_o(flag_clr)
  );

  rtos_timer_core #(.W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i, .dbg_halt_i,
    .ctrl_i(ctrl), .preload_i(preload), .start_edge_i(start_edge),
    .flag_clr_i(flag_clr), .count_o(count), .flag_o(flag)
  );

  assign irq_o = flag & irq_en;

  p_ro_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_COUNT && !tick_i) |=> $stable(count));
endmodule

// File: tb/rtos_down_timer_test.sv
module rtos_down_timer_test;
  logic clk = 0, rst_ni = 0, tick = 0, halt = 0, req = 0, we = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rtos_down_timer uut (
    .clk_i(clk), .rst_ni, .tick_i(tick), .dbg_halt_i(halt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1", v, 0);
    end
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(1, 10); wr(2, 3);
    rd(0, v); chk("R3 load", v, 10);
    ticks(3); rd(0, v); chk("R4 dec", v, 7);
    wr(2, 3); rd(0, v); chk("R3 no reload", v, 7);
    wr(0, 55); rd(0, v); chk("R2", v, 7);
    idle(5); rd(0, v); chk("R4 hold", v, 7);
    wr(1, 100); rd(0, v); chk("R6 deferred", v, 7);
    ticks(6); rd(3, v); chk("R7 not yet", v, 0);
    ticks(1); rd(0, v); chk("R7 zero", v, 0);
    rd(3, v); chk("R7 flag", v, 1);
    chk("R9 gated", irq, 0);
    wr(3, 2); chk("R9 irq", irq, 1);
    ticks(3); rd(0, v); chk("R11 stays", v, 0);
    wr(3, 3); rd(3, v); chk("R8 w1c", v, 2);
    chk("R9 low", irq, 0);
    ticks(2); rd(3, v); chk("R11 no refire", v, 2);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(2, 0); wr(1, 5); wr(2, 2);
    rd(0, v); chk("R3 load", v, 5);
    ticks(3); rd(0, v); chk("R5 ignored", v, 5);
    rd(1, v); chk("R5 write", v, 5);
    wr(2, 3); rd(0, v); chk("R3 held", v, 5);
    ticks(2); rd(0, v); chk("R4 dec", v, 3);
    wr(2, 0); ticks(2); rd(0, v); chk("R12 stop", v, 3);
  endtask

  task automatic t_halt;
    logic [31:0] v;
    wr(1, 20); wr(2, 7);
    rd(0, v); chk("R3 load", v, 20);
    halt = 1; ticks(4); rd(0, v); chk("R10 frozen", v, 20);
    wr(2, 3); ticks(2); rd(0, v); chk("R10 no halt_en", v, 18);
    halt = 0;
  endtask

  task automatic t_zero_preload;
    logic [31:0] v;
    wr(2, 0); wr(1, 0); wr(2, 3);
    rd(3, v); chk("R7 idle", v, 2);
    ticks(1); rd(3, v); chk("R7 zero pre", v, 3);
    wr(3, 0); rd(3, v); chk("R8 w0", v, 1);
    chk("R9 disabled", irq, 0);
    ticks(2); wr(3, 1); rd(3, v); chk("R11 once", v, 0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(2, 0); wr(1, 3); wr(2, 11);
    ticks(1); rd(0, v); chk("R4 dec", v, 2);
    wr(1, 5); rd(0, v); chk("R6 running", v, 2);
    ticks(2); rd(0, v); chk("R6 reload", v, 5);
    rd(3, v); chk("R7 reload flag", v, 1);
    ticks(1); rd(0, v); chk("R6 after", v, 4);
  endtask

  initial begin
    idle(3); rst_ni = 1; idle(1);
    t_reset; t_oneshot; t_disabled; t_halt; t_zero_preload; t_reload;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule